// File: doc/BRIEF.md
# Prescaled Timer with Overflow Interrupt

A free-running up-counter peripheral that sits on a simple byte-wide register bus. Software sets it up through a control register: whether it runs, whether it wraps at 8 or at 16 bits, whether it counts the system clock or edges of an external input (and which edge), and whether a hidden 8-bit divider sits in front of the counter, at which power-of-two ratio.

Each wrap of the counter sets a sticky interrupt flag. The interrupt output is that flag gated by an enable bit. Software clears the flag by writing it. A sleep input freezes counting. The divider's running count cannot be read or written. Any write to the count bytes resets it, and the write leaves the divider's configuration as it was.

Top module: `prescaled_timer`

## Requirements
- R1: After reset every register reads 0 (control at address 0, count low byte at 1, count high byte at 2, interrupt register at 3), the hidden divider is 0 and `irq` is low.
- R2: Control bit 7 is run, bit 6 selects 8-bit wrap (1) or 16-bit wrap (0), and bit 3 set bypasses the divider. When running, bypassed and on the internal source, the count rises by exactly one on every clock.
- R3: With bit 3 clear, the ratio code k in bits 2:0 makes the count rise once per 2^(k+1) source ticks. Code 0 gives 1:2 and code 7 gives 1:256.
- R4: A write to address 1 or 2 clears the hidden divider. The control register keeps its value.
- R5: In 8-bit mode the count wraps from FFh to 00h in the low byte and sets the flag. The high byte is not changed by counting.
- R6: In 16-bit mode the low byte carries into the high byte, and only the wrap from FFFFh to 0000h sets the flag.
- R7: Address 3 holds the flag in bit 0 and the enable in bit 1. `irq` is high exactly when both are set.
- R8: The flag stays set until software writes 0 to bit 0. If an overflow falls in the same cycle as that write, the flag stays set.
- R9: While `sleep` is high or run is 0, the count and the divider hold, and no overflow occurs.
- R10: Control bit 5 set selects `ext_in` as the source. The input passes through a two-stage synchronizer. Bit 4 set counts falling edges, and bit 4 clear counts rising edges.
- R11: A count write in the same cycle as an increment wins. That cycle neither increments nor sets the flag.
- R12: The ratio and the bypass bit may change while running. A divider count at or above the new ratio's limit wraps on its next tick and yields an increment. While bypassed, the divider is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | Freezes counting while high |
| ext_in | input | 1 | Asynchronous external count input |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| irq | output | 1 | Flag AND enable |

## Verification
The bench builds the block at its default parameters: a two-stage synchronizer, and a 3-bit ratio field over an 8-bit divider. At those values the longest division (1:256) can be reached in a few hundred cycles. The 16-bit wrap is reached within a handful of cycles by preloading the count bytes near FFFFh. A behavioural model in the bench tracks every register and the divider, and its result is compared with the read port and the interrupt on every clock. Directed scenarios time bus writes to land on the cycle of an increment or an overflow, so the priority rules can be observed at the ports.

// File: rtl/ptmr_pkg.sv
// Shared constants and the control register layout for the prescaled timer.
// Assumes a byte-wide bus and a 3-bit ratio field, so the divider is 8 bits.
package ptmr_pkg;
    localparam int unsigned BUS_W   = 8;
    localparam int unsigned ADDR_W  = 2;
    localparam int unsigned RATIO_W = 3;
    localparam int unsigned LANES   = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CNTLO = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_CNTHI = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_IRQ   = 2'd3;

    typedef struct packed {
        logic               run;
        logic               narrow;
        logic               ext_src;
        logic               fall_edge;
        logic               bypass;
        logic [RATIO_W-1:0] ratio;
    } ctrl_t;
endpackage

// File: rtl/ptmr_tick_src.sv
// Source selection for the timer. The external input is synchronized,
// then one of its edges is detected. Otherwise every clock is a tick.
// Assumes ext_pin is asynchronous. The synchronizer always runs, so it
// holds a settled value when the source is switched.
module ptmr_tick_src #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin,
    input  logic use_ext,
    input  logic fall_sel,
    output logic src_tick
);
    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               synced;
    logic               prior;
    logic               rise_seen;
    logic               fall_seen;

    // Shift the pin through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], ext_pin};
        end
    end

    // Compare the synchronized level with its previous value.
    always_comb begin
        synced    = chain_q[CHAIN_W-2];
        prior     = chain_q[CHAIN_W-1];
        rise_seen = synced & ~prior;
        fall_seen = ~synced & prior;
        if (use_ext) begin
            src_tick = fall_sel ? fall_seen : rise_seen;
        end else begin
            src_tick = 1'b1;
        end
    end
endmodule

// File: rtl/ptmr_prescaler.sv
// Hidden power-of-two divider. It counts gated source ticks and emits a
// step each time it reaches the limit for the selected ratio.
// Assumes clear and bypass hold it at zero. The comparison is ">=", so a
// count left above a newly lowered limit wraps on the next tick.
module ptmr_prescaler #(
    parameter int unsigned RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               bypass,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               clear,
    output logic               step
);
    localparam int unsigned PRE_W = 1 << RATIO_W;
    localparam logic [RATIO_W-1:0] TOP_SHIFT = RATIO_W'(PRE_W - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;
    logic             reached;

    // Derive the wrap limit 2^(ratio+1)-1 and the step output.
    always_comb begin
        limit   = {PRE_W{1'b1}} >> (TOP_SHIFT - ratio);
        reached = (pre_q >= limit);
        step    = bypass ? tick_en : (tick_en & reached);
    end

    // Advance or clear the hidden divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear || bypass) begin
            pre_q <= '0;
        end else if (tick_en) begin
            pre_q <= reached ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptmr_counter.sv
// Byte-lane up-counter with a selectable wrap width. Lane 0 always counts.
// Higher lanes count only in full-width mode, via a ripple carry.
// Assumes a load on any lane blocks the increment of all lanes in that
// cycle, and that wrap is then low.
module ptmr_counter #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    narrow,
    input  logic [LANES-1:0]        load,
    input  logic [BYTE_W-1:0]       load_val,
    output logic [LANES*BYTE_W-1:0] count,
    output logic                    wrap
);
    logic [LANES:0]   carry;
    logic [LANES-1:0] lane_full;
    logic             loading;

    // A load on any lane suppresses counting this cycle.
    always_comb begin
        loading  = |load;
        carry[0] = step & ~loading;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        logic              lane_go;

        // Lane g counts on its carry. Upper lanes are frozen in narrow mode.
        always_comb begin
            lane_full[g] = &lane_q;
            if (g == 0) begin
                lane_go = carry[g];
            end else begin
                lane_go = carry[g] & ~narrow;
            end
            carry[g+1] = lane_go & lane_full[g];
        end

        // Update one byte lane: a load wins over an increment.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (load[g]) begin
                lane_q <= load_val;
            end else if (lane_go) begin
                lane_q <= lane_q + 1'b1;
            end
        end

        assign count[g*BYTE_W +: BYTE_W] = lane_q;
    end

    // Overflow leaves lane 0 in narrow mode and the top lane otherwise.
    always_comb begin
        wrap = narrow ? carry[1] : carry[LANES];
    end
endmodule

// File: rtl/prescaled_timer.sv
// Top level of the prescaled timer. It decodes the register bus, holds the
// control, flag and enable bits, and chains the source, divider and counter.
// Assumes single-cycle bus writes and a combinational read of the addressed
// register. The flag is set by overflow and written only by software.
module prescaled_timer
    import ptmr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              ext_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int unsigned CNT_W = LANES * BUS_W;

    ctrl_t            ctrl_q;
    logic             flag_q;
    logic             en_q;
    logic             wr_ctrl;
    logic             wr_irq;
    logic [LANES-1:0] wr_cnt;
    logic             src_tick;
    logic             tick_en;
    logic             step;
    logic             wrap;
    logic [CNT_W-1:0] count_q;

    // Decode the write strobe per register.
    always_comb begin
        wr_ctrl   = bus_we && (bus_addr == ADR_CTRL);
        wr_irq    = bus_we && (bus_addr == ADR_IRQ);
        wr_cnt[0] = bus_we && (bus_addr == ADR_CNTLO);
        wr_cnt[1] = bus_we && (bus_addr == ADR_CNTHI);
    end

    // Gate source ticks with the run bit and the sleep input.
    always_comb begin
        tick_en = src_tick & ctrl_q.run & ~sleep;
    end

    ptmr_tick_src #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_pin (ext_in),
        .use_ext (ctrl_q.ext_src),
        .fall_sel(ctrl_q.fall_edge),
        .src_tick(src_tick)
    );

    ptmr_prescaler #(
        .RATIO_W(RATIO_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .bypass (ctrl_q.bypass),
        .ratio  (ctrl_q.ratio),
        .clear  (|wr_cnt),
        .step   (step)
    );

    ptmr_counter #(
        .BYTE_W(BUS_W),
        .LANES (LANES)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .narrow  (ctrl_q.narrow),
        .load    (wr_cnt),
        .load_val(bus_wdata),
        .count   (count_q),
        .wrap    (wrap)
    );

    // Hold the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(bus_wdata);
        end
    end

    // Set the flag on overflow. A software write may change it, but an
    // overflow in the same cycle keeps it set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            flag_q <= wrap | (wr_irq ? bus_wdata[0] : flag_q);
            if (wr_irq) begin
                en_q <= bus_wdata[1];
            end
        end
    end

    // Return the addressed register and drive the masked interrupt.
    always_comb begin
        unique case (bus_addr)
            ADR_CTRL:  bus_rdata = ctrl_q;
            ADR_CNTLO: bus_rdata = count_q[BUS_W-1:0];
            ADR_CNTHI: bus_rdata = count_q[CNT_W-1:BUS_W];
            default:   bus_rdata = {{(BUS_W-2){1'b0}}, en_q, flag_q};
        endcase
        irq = flag_q & en_q;
    end
endmodule

// File: rtl/ptmr_checker.sv
// Temporal checks on the prescaled timer, bound to every instance of it.
// Assumes the default package layout: bit 7 run and bit 6 narrow.
module ptmr_checker
    import ptmr_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sleep,
    input logic                    bus_we,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic                    irq,
    input logic [BUS_W-1:0]        ctrl_bits,
    input logic [LANES*BUS_W-1:0]  count,
    input logic                    flag
);
    logic cnt_wr;
    logic flag_wr;

    // Classify the bus write of the current cycle.
    always_comb begin
        cnt_wr  = bus_we && ((bus_addr == ADR_CNTLO) || (bus_addr == ADR_CNTHI));
        flag_wr = bus_we && (bus_addr == ADR_IRQ);
    end

    assert_irq_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_wr) |=> flag);

    assert_sleep_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !cnt_wr) |=> $stable(count));

    assert_stop_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[7] && !cnt_wr) |=> $stable(count));

    assert_write_no_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !flag) |=> !flag);

    assert_high_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bits[6] && !cnt_wr) |=> $stable(count[LANES*BUS_W-1:BUS_W]));

    assert_unit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[6] && !cnt_wr) |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));

    assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !flag_wr && ctrl_bits[6]) |=> (!flag || (count[BUS_W-1:0] == '0)));
endmodule

bind prescaled_timer ptmr_checker u_ptmr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .irq      (irq),
    .ctrl_bits(ctrl_q),
    .count    (count_q),
    .flag     (flag_q)
);

// File: tb/prescaled_timer_bench.sv
`timescale 1ns/100ps
// Bench for the prescaled timer: a behavioural model compared every clock,
// plus directed scenarios with values derived by hand.
module prescaled_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep = 1'b0;
    logic       ext_in = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;

    int    vectors = 0;
    int    fails = 0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Model state
    int m_ctl, m_lo, m_hi, m_flag, m_en, m_pre, m_s1, m_s2, m_s3;
    int m_tick, m_inc, m_ovf, m_wcnt, m_lim, m_full;

    prescaled_timer u_prescaled_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .ext_in   (ext_in),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    always #2.5 clk = ~clk;

    // Advance the model on each rising edge from the inputs held there.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = 0; m_lo = 0; m_hi = 0; m_flag = 0; m_en = 0; m_pre = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            m_tick = 1;
            if (m_ctl[5]) m_tick = m_ctl[4] ? int'(m_s2 == 0 && m_s3 == 1) : int'(m_s2 == 1 && m_s3 == 0);
            m_tick = int'(m_tick != 0 && m_ctl[7] && !sleep);
            m_wcnt = int'(bus_we && (bus_addr == 2'd1 || bus_addr == 2'd2));
            m_inc = 0;
            m_ovf = 0;
            if (m_ctl[3]) begin
                m_inc = m_tick;
                m_pre = 0;
            end else if (m_tick != 0) begin
                m_lim = (2 << m_ctl[2:0]) - 1;
                if (m_pre >= m_lim) begin
                    m_pre = 0;
                    m_inc = 1;
                end else begin
                    m_pre = m_pre + 1;
                end
            end
            if (m_wcnt != 0) begin
                m_pre = 0;
                if (bus_addr == 2'd1) m_lo = int'(bus_wdata);
                else m_hi = int'(bus_wdata);
            end else if (m_inc != 0) begin
                if (m_ctl[6]) begin
                    m_ovf = int'(m_lo == 255);
                    m_lo = (m_lo + 1) % 256;
                end else begin
                    m_full = m_hi * 256 + m_lo;
                    m_ovf = int'(m_full == 65535);
                    m_full = (m_full + 1) % 65536;
                    m_hi = m_full / 256;
                    m_lo = m_full % 256;
                end
            end
            if (bus_we && bus_addr == 2'd3) begin
                m_flag = int'(m_ovf != 0 || bus_wdata[0]);
                m_en = int'(bus_wdata[1]);
            end else if (m_ovf != 0) begin
                m_flag = 1;
            end
            if (bus_we && bus_addr == 2'd0) m_ctl = int'(bus_wdata);
            m_s3 = m_s2;
            m_s2 = m_s1;
            m_s1 = int'(ext_in);
        end
    end

    function automatic int model_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_ctl;
            2'd1:    return m_lo;
            2'd2:    return m_hi;
            default: return m_en * 2 + m_flag;
        endcase
    endfunction

    // Compare the read port and the interrupt with the model every clock.
    always @(negedge clk) begin
        if (rst_n && started && !done) begin
            vectors++;
            if (bus_rdata !== 8'(model_read(bus_addr)) || irq !== (m_flag != 0 && m_en != 0)) begin
                fails++;
                $display("FAIL %s per-cycle: addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                         cur_req, bus_addr, bus_rdata, irq, 8'(model_read(bus_addr)),
                         (m_flag != 0 && m_en != 0));
            end
        end
    end

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic check_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk); #1;
        bus_addr = a;
        #0.2;
        vectors++;
        if (bus_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr %0d: got %h expected %h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic check_irq(input string req, input logic exp);
        vectors++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq: got %b expected %b", req, irq, exp);
        end
    endtask

    // Start with ctl, wait n cycles, stop: the count sees n+2 source edges.
    task automatic run_window(input logic [7:0] ctl, input int n);
        write_reg(2'd0, ctl);
        repeat (n) @(negedge clk);
        write_reg(2'd0, ctl & 8'h7F);
    endtask

    task automatic preload(input logic [7:0] hi, input logic [7:0] lo);
        write_reg(2'd2, hi);
        write_reg(2'd1, lo);
    endtask

    task automatic ext_hold(input logic v, input int n);
        @(negedge clk); #1;
        ext_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        started = 1'b1;

        // R1: reset state
        cur_req = "R1";
        check_reg("R1", 2'd0, 8'h00);
        check_reg("R1", 2'd1, 8'h00);
        check_reg("R1", 2'd2, 8'h00);
        check_reg("R1", 2'd3, 8'h00);
        check_irq("R1", 1'b0);

        // R2: bypassed internal source, 10 edges
        cur_req = "R2";
        run_window(8'hC8, 8);
        check_reg("R2", 2'd1, 8'h0A);

        // R3: ratio code 2 (1:8), 32 edges give 4 counts
        cur_req = "R3";
        preload(8'h00, 8'h00);
        run_window(8'hC2, 30);
        check_reg("R3", 2'd1, 8'h04);

        // R4: divider at 5, count write clears it, control unchanged
        cur_req = "R4";
        preload(8'h00, 8'h00);
        run_window(8'hC2, 3);
        write_reg(2'd1, 8'h20);
        check_reg("R4", 2'd0, 8'h42);
        run_window(8'hC2, 4);
        check_reg("R4", 2'd1, 8'h20);

        // R5: 8-bit wrap with the enable clear
        cur_req = "R5";
        preload(8'h12, 8'hFE);
        write_reg(2'd3, 8'h00);
        run_window(8'hC8, 0);
        check_reg("R5", 2'd1, 8'h00);
        check_reg("R5", 2'd2, 8'h12);
        check_reg("R5", 2'd3, 8'h01);
        check_irq("R7", 1'b0);

        // R8: the flag persists, then is cleared by software
        cur_req = "R8";
        repeat (5) @(negedge clk);
        check_reg("R8", 2'd3, 8'h01);

        // R7: irq is flag AND enable
        cur_req = "R7";
        write_reg(2'd3, 8'h03);
        check_reg("R7", 2'd3, 8'h03);
        check_irq("R7", 1'b1);
        write_reg(2'd3, 8'h02);
        check_reg("R8", 2'd3, 8'h02);
        check_irq("R7", 1'b0);
        write_reg(2'd3, 8'h01);
        check_irq("R7", 1'b0);
        write_reg(2'd3, 8'h00);

        // R8: overflow and a clear in the same cycle keep the flag set
        cur_req = "R8";
        preload(8'h00, 8'hFE);
        write_reg(2'd0, 8'hC8);
        write_reg(2'd3, 8'h00);
        write_reg(2'd0, 8'h48);
        check_reg("R8", 2'd3, 8'h01);
        check_reg("R8", 2'd1, 8'h02);
        write_reg(2'd3, 8'h00);

        // R6: 16-bit wrap and carry without a flag
        cur_req = "R6";
        preload(8'hFF, 8'hFE);
        run_window(8'h88, 0);
        check_reg("R6", 2'd1, 8'h00);
        check_reg("R6", 2'd2, 8'h00);
        check_reg("R6", 2'd3, 8'h01);
        write_reg(2'd3, 8'h00);
        preload(8'h00, 8'hFE);
        run_window(8'h88, 0);
        check_reg("R6", 2'd2, 8'h01);
        check_reg("R6", 2'd1, 8'h00);
        check_reg("R6", 2'd3, 8'h00);

        // R9: sleep freezes the count
        cur_req = "R9";
        preload(8'h00, 8'h00);
        @(negedge clk); #1 sleep = 1'b1;
        run_window(8'hC8, 8);
        check_reg("R9", 2'd1, 8'h00);
        @(negedge clk); #1 sleep = 1'b0;

        // R10: rising edges on the external input
        cur_req = "R10";
        preload(8'h00, 8'h00);
        write_reg(2'd0, 8'hE8);
        for (int i = 0; i < 3; i++) begin
            ext_hold(1'b1, 3);
            ext_hold(1'b0, 3);
        end
        ext_hold(1'b1, 5);
        write_reg(2'd0, 8'h68);
        check_reg("R10", 2'd1, 8'h04);

        // R10: falling edges on the external input
        preload(8'h00, 8'h00);
        write_reg(2'd0, 8'hF8);
        ext_hold(1'b0, 3);
        for (int i = 0; i < 2; i++) begin
            ext_hold(1'b1, 3);
            ext_hold(1'b0, 3);
        end
        repeat (5) @(negedge clk);
        write_reg(2'd0, 8'h78);
        check_reg("R10", 2'd1, 8'h03);

        // R11: a write in the same cycle as the overflow increment wins
        cur_req = "R11";
        preload(8'h00, 8'hFE);
        write_reg(2'd0, 8'hC8);
        write_reg(2'd1, 8'h10);
        write_reg(2'd0, 8'h48);
        check_reg("R11", 2'd1, 8'h12);
        check_reg("R11", 2'd3, 8'h00);

        // R12: ratio lowered while running, divider at 22 wraps at once
        cur_req = "R12";
        preload(8'h00, 8'h00);
        write_reg(2'd0, 8'hC7);
        repeat (20) @(negedge clk);
        write_reg(2'd0, 8'hC0);
        repeat (2) @(negedge clk);
        write_reg(2'd0, 8'h40);
        check_reg("R12", 2'd1, 8'h02);

        // R12: bypass on the fly then back, the divider restarts from 0
        preload(8'h00, 8'h00);
        write_reg(2'd0, 8'hC1);
        write_reg(2'd0, 8'hC9);
        write_reg(2'd0, 8'hC1);
        repeat (2) @(negedge clk);
        write_reg(2'd0, 8'h41);
        check_reg("R12", 2'd1, 8'h03);

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule